// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block conditions the two PWM commands of one inverter leg, one for the upper switch and one for the lower switch, into two gate-enable outputs. Both commands are active high and already synchronous to the block clock. The block guarantees that the two enables are never high together.

Each command first passes a glitch filter that ignores any level that does not hold for a minimum number of cycles. The filtered commands are then arbitrated by arrival order. The side that asserts first keeps the leg for as long as its command stays high, and a request from the other side during that overlap is dropped. If both commands rise on the same cycle, the lower switch wins.

A blanking stage holds off each enable until the opposite enable has been low for a programmable number of cycles. An external force-off input clears both enables. A three-phase inverter uses three instances.

Top module: `hbi_leg_interlock`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `hi_en` and `lo_en` are both 0.
- R2: `hi_en` and `lo_en` are never 1 in the same cycle.
- R3: When `hi_cmd` was asserted first, `lo_en` stays 0 for as long as `hi_cmd` stays high, whatever `lo_cmd` does.
- R4: When `lo_cmd` was asserted first, `hi_en` stays 0 for as long as `lo_cmd` stays high, whatever `hi_cmd` does.
- R5: When both commands rise on the same cycle and stay high, only `lo_en` turns on.
- R6: A command level held for fewer than `MIN_PW` consecutive clock samples causes no output change. This applies both to a short high pulse and to a short low gap.
- R7: An enable rises only after the opposite enable has been low for at least `BLANK` full cycles.
- R8: When the owning command is released while the other command is still high, the other enable turns on once blanking has elapsed. It turns on only if that command is still high.
- R9: A cycle with `force_off` high makes both enables 0 on the next cycle. After `force_off` returns low, a still-valid owner regains its enable.
- R10: A command change held steady reaches its enable on the (`MIN_PW`+2)-th rising edge that samples the new level, provided blanking is already met. With the defaults (`MIN_PW`=4) this is 6 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | 1 | Upper-switch PWM command, active high |
| lo_cmd | input | 1 | Lower-switch PWM command, active high |
| force_off | input | 1 | Forces both enables low while high |
| hi_en | output | 1 | Upper-switch gate enable |
| lo_en | output | 1 | Lower-switch gate enable |

## Verification
The bench targets overlap in both orders, simultaneous rise, release of the owner while the other command is still held, and glitches that are one cycle short of the filter width, both high pulses and low gaps. A design that arbitrated on raw inputs would let a short pulse steal the leg. A design with an off-by-one blanking counter would raise the new enable a cycle early, which the blanking assertions catch directly. A design that favoured the upper side on simultaneous rise would turn on `hi_en`. A design that skipped the force-off path would leave an enable high through the shutdown window.

// File: rtl/hbi_pkg.sv
// Shared types for the half-bridge interlock.
package hbi_pkg;
    // Which side currently owns the leg.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HIGH = 2'd1,
        OWN_LOW  = 2'd2
    } own_t;
endpackage

// File: rtl/hbi_pulse_filter.sv
// Glitch filter: the output follows the input only after the input has held
// a new level for MIN_PW consecutive clock samples.
// Assumes the input is already synchronous to clk.
module hbi_pulse_filter #(
    parameter int MIN_PW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(MIN_PW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);

    logic [CW-1:0] run_q;
    logic          lvl_q;

    // Count samples that disagree with the held level; commit on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            lvl_q <= 1'b0;
        end else if (raw_i == lvl_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            lvl_q <= raw_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign clean_o = lvl_q;
endmodule

// File: rtl/hbi_order_arb.sv
// Arrival-order arbiter: the first filtered command to assert owns the leg
// until it is released. Simultaneous assertion goes to the low side.
// Assumes filtered inputs change at most once per cycle.
module hbi_order_arb
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_f_i,
    input  logic lo_f_i,
    output own_t own_o
);
    own_t own_q, own_d;

    // Next owner from current owner and filtered commands.
    always_comb begin
        own_d = own_q;
        unique case (own_q)
            OWN_HIGH: if (!hi_f_i) own_d = lo_f_i ? OWN_LOW : OWN_NONE;
            OWN_LOW:  if (!lo_f_i) own_d = hi_f_i ? OWN_HIGH : OWN_NONE;
            default: begin
                if (lo_f_i)      own_d = OWN_LOW;
                else if (hi_f_i) own_d = OWN_HIGH;
                else             own_d = OWN_NONE;
            end
        endcase
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= OWN_NONE;
        else        own_q <= own_d;
    end

    assign own_o = own_q;
endmodule

// File: rtl/hbi_blank_gate.sv
// Blanking gate: registers the two enables. An enable may rise only when
// the opposite enable has been low for BLANK cycles. force_off clears both.
// Assumes req_hi_i and req_lo_i are never high together.
module hbi_blank_gate #(
    parameter int BLANK = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off_i,
    input  logic req_hi_i,
    input  logic req_lo_i,
    output logic hi_en_o,
    output logic lo_en_o
);
    localparam int BW = $clog2(BLANK + 2);
    localparam logic [BW-1:0] FULL = BW'(BLANK);

    logic [1:0]          en_q;      // [0] high side, [1] low side
    logic [1:0]          en_d;
    logic [1:0][BW-1:0]  off_q;     // cycles each side has been low
    logic [1:0]          req;

    assign req = {req_lo_i, req_hi_i};

    genvar s;
    generate
        for (s = 0; s < 2; s++) begin : g_side
            // Enable decision for side s, gated by the opposite side.
            always_comb begin
                en_d[s] = req[s] && !force_off_i && !en_q[1-s]
                          && (off_q[1-s] == FULL);
            end

            // Saturating off-time counter for side s.
            always_ff @(posedge clk) begin
                if (!rst_n)                off_q[s] <= FULL;
                else if (en_q[s])          off_q[s] <= '0;
                else if (off_q[s] != FULL) off_q[s] <= off_q[s] + 1'b1;
            end
        end
    endgenerate

    // Enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 2'b00;
        else        en_q <= en_d;
    end

    assign hi_en_o = en_q[0];
    assign lo_en_o = en_q[1];
endmodule

// File: rtl/hbi_leg_interlock.sv
// One inverter leg: filters both commands, arbitrates by arrival order and
// applies blanking before driving the gate enables.
// Assumes synchronous active-high commands and a synchronous active-low reset.
module hbi_leg_interlock
    import hbi_pkg::*;
#(
    parameter int MIN_PW = 4,
    parameter int BLANK  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic force_off,
    output logic hi_en,
    output logic lo_en
);
    logic [1:0] raw_cmd;
    logic [1:0] clean_cmd;
    own_t       owner;

    assign raw_cmd = {lo_cmd, hi_cmd};

    genvar c;
    generate
        for (c = 0; c < 2; c++) begin : g_filt
            hbi_pulse_filter #(.MIN_PW(MIN_PW)) filt_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_i   (raw_cmd[c]),
                .clean_o (clean_cmd[c])
            );
        end
    endgenerate

    hbi_order_arb arb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_f_i (clean_cmd[0]),
        .lo_f_i (clean_cmd[1]),
        .own_o  (owner)
    );

    hbi_blank_gate #(.BLANK(BLANK)) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_off_i (force_off),
        .req_hi_i    (owner == OWN_HIGH),
        .req_lo_i    (owner == OWN_LOW),
        .hi_en_o     (hi_en),
        .lo_en_o     (lo_en)
    );
endmodule

// File: rtl/hbi_leg_interlock_chk.sv
// Port-level checker for hbi_leg_interlock, bound to every instance.
module hbi_leg_interlock_chk #(
    parameter int BLANK = 3
) (
    input logic clk,
    input logic rst_n,
    input logic force_off,
    input logic hi_en,
    input logic lo_en
);
    int hi_low_run;
    int lo_low_run;

    // Independent low-time counters on the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_low_run <= BLANK;
            lo_low_run <= BLANK;
        end else begin
            hi_low_run <= hi_en ? 0 : ((hi_low_run < BLANK) ? hi_low_run + 1 : hi_low_run);
            lo_low_run <= lo_en ? 0 : ((lo_low_run < BLANK) ? lo_low_run + 1 : lo_low_run);
        end
    end

    a_r1_reset_off: assert property (@(posedge clk) !rst_n |=> (!hi_en && !lo_en));

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(hi_en && lo_en));

    a_r7_blank_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> ($past(hi_low_run) >= BLANK));

    a_r7_blank_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> ($past(lo_low_run) >= BLANK));

    a_r9_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!hi_en && !lo_en));
endmodule

bind hbi_leg_interlock hbi_leg_interlock_chk #(.BLANK(BLANK)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_off (force_off),
    .hi_en     (hi_en),
    .lo_en     (lo_en)
);

// File: tb/hbi_leg_interlock_tb_top.sv
module hbi_leg_interlock_tb_top;
    localparam int MIN_PW = 4;
    localparam int BLANK  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd = 1'b0;
    logic force_off = 1'b0;
    logic hi_en, lo_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    bit saw_hi = 0;
    bit saw_lo = 0;

    always #2 clk = ~clk;

    hbi_leg_interlock #(.MIN_PW(MIN_PW), .BLANK(BLANK)) dut_i (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .force_off(force_off), .hi_en(hi_en), .lo_en(lo_en)
    );

    // Behavioural reference: stable-run counters, owner by arrival, blanking.
    int  m_run[2];
    bit  m_lvl[2];
    int  m_owner;            // 0 none, 1 high side, 2 low side
    bit  m_en[2];
    int  m_off[2];

    always @(posedge clk) begin
        bit cmd[2];
        bit n_lvl[2];
        int n_run[2];
        int n_owner;
        bit n_en[2];
        int n_off[2];
        cmd[0] = hi_cmd;
        cmd[1] = lo_cmd;
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_run[i] = 0; m_lvl[i] = 0; m_en[i] = 0; m_off[i] = BLANK;
            end
            m_owner = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                n_en[i] = (m_owner == i + 1) && !force_off && !m_en[1-i] && (m_off[1-i] >= BLANK);
                n_off[i] = m_en[i] ? 0 : ((m_off[i] < BLANK) ? m_off[i] + 1 : m_off[i]);
                n_lvl[i] = m_lvl[i];
                n_run[i] = 0;
                if (cmd[i] != m_lvl[i]) begin
                    if (m_run[i] + 1 >= MIN_PW) n_lvl[i] = cmd[i];
                    else                        n_run[i] = m_run[i] + 1;
                end
            end
            n_owner = m_owner;
            if (m_owner == 1 && !m_lvl[0])      n_owner = m_lvl[1] ? 2 : 0;
            else if (m_owner == 2 && !m_lvl[1]) n_owner = m_lvl[0] ? 1 : 0;
            else if (m_owner == 0)              n_owner = m_lvl[1] ? 2 : (m_lvl[0] ? 1 : 0);
            for (int i = 0; i < 2; i++) begin
                m_en[i] = n_en[i]; m_off[i] = n_off[i];
                m_lvl[i] = n_lvl[i]; m_run[i] = n_run[i];
            end
            m_owner = n_owner;
        end
    end

    // Per-cycle comparison against the model (R2..R10 overall behaviour).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (hi_en !== m_en[0] || lo_en !== m_en[1]) begin
                errors++;
                $display("FAIL R2-model mismatch t=%0t: act hi=%0b lo=%0b exp hi=%0b lo=%0b",
                         $time, hi_en, lo_en, m_en[0], m_en[1]);
            end
            if (hi_en) saw_hi = 1;
            if (lo_en) saw_lo = 1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %0b exp %0b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        chk("R1 hi_en in reset", hi_en, 1'b0);
        chk("R1 lo_en in reset", lo_en, 1'b0);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 hi_en after release", hi_en, 1'b0);

        // R10 latency and R3 high-first overlap.
        hi_cmd = 1;
        wait_n(5);
        chk("R10 hi_en not yet at 5 edges", hi_en, 1'b0);
        wait_n(1);
        chk("R10 hi_en at 6 edges", hi_en, 1'b1);
        lo_cmd = 1;
        wait_n(12);
        chk("R3 lo_en held off", lo_en, 1'b0);
        chk("R3 hi_en kept", hi_en, 1'b1);

        // R8/R7 release of owner: lo_en after blanking.
        hi_cmd = 0;
        wait_n(6);
        chk("R7 hi_en dropped", hi_en, 1'b0);
        chk("R7 lo_en still blanked", lo_en, 1'b0);
        wait_n(3);
        chk("R7 lo_en blanked one edge before", lo_en, 1'b0);
        wait_n(1);
        chk("R8 lo_en after blanking", lo_en, 1'b1);
        lo_cmd = 0;
        wait_n(12);

        // R5 simultaneous rise.
        hi_cmd = 1; lo_cmd = 1;
        wait_n(10);
        chk("R5 lo_en wins", lo_en, 1'b1);
        chk("R5 hi_en suppressed", hi_en, 1'b0);
        // R4 low-first: hi request ignored during overlap, incl. a short hi pulse.
        hi_cmd = 0; wait_n(8);
        hi_cmd = 1; wait_n(3); hi_cmd = 0; wait_n(8);
        chk("R4 hi_en stays off", hi_en, 1'b0);
        chk("R4 lo_en kept", lo_en, 1'b1);
        // R8 mirror: lo released with hi still high.
        hi_cmd = 1; wait_n(8);
        lo_cmd = 0;
        wait_n(9);
        chk("R8 hi_en not before blanking", hi_en, 1'b0);
        wait_n(1);
        chk("R8 hi_en after blanking", hi_en, 1'b1);
        // R8: release of owner when other command already gone -> nothing.
        hi_cmd = 0; wait_n(15);
        chk("R8 both off after release", hi_en | lo_en, 1'b0);

        // R6 short high pulse on idle leg.
        saw_hi = 0;
        hi_cmd = 1; wait_n(MIN_PW - 1); hi_cmd = 0;
        wait_n(12);
        chk("R6 short hi pulse ignored", saw_hi, 1'b0);
        saw_lo = 0;
        lo_cmd = 1; wait_n(MIN_PW - 1); lo_cmd = 0;
        wait_n(12);
        chk("R6 short lo pulse ignored", saw_lo, 1'b0);
        // R6 short low gap while on.
        hi_cmd = 1; wait_n(10);
        hi_cmd = 0; wait_n(MIN_PW - 1); hi_cmd = 1;
        for (int k = 0; k < 8; k++) begin
            wait_n(1);
            chk("R6 hi_en through short gap", hi_en, 1'b1);
        end

        // R9 force_off.
        force_off = 1;
        wait_n(1);
        chk("R9 hi_en forced low", hi_en, 1'b0);
        wait_n(4);
        chk("R9 hi_en held low", hi_en, 1'b0);
        force_off = 0;
        wait_n(2);
        chk("R9 hi_en returns", hi_en, 1'b1);
        hi_cmd = 0;
        wait_n(12);
        chk("R2 idle end", hi_en | lo_en, 1'b0);

        finish_run();
    end
endmodule